// File: doc/BRIEF.md
# Drift Hit Time Classifier

This block sorts the discriminator hits of one group of drift-chamber sense wires into two drift-time windows. The windows are measured from the start of each beam-crossing period. A crossing strobe marks the start of every period, and an internal tick counter measures how far into the period each clock cycle lies. Two programmable tick boundaries divide the period into three windows: an early (prompt) window, a late (delayed) window, and a tail that lies beyond the maximum drift time. A hit on a wire sets that wire's prompt flag or its delayed flag according to the window it arrives in. A hit in the tail is dropped.

The flags of each wire build up over a whole period, and a wire can finish the period with both flags set. When the next crossing strobe arrives, the block copies the built-up flags into a registered output word holding two bits per wire and raises a one-cycle valid pulse. In the same cycle it restarts the build-up, so a hit that arrives in the strobe cycle is kept and counted in the new period. With the default settings the block serves one cell of twelve wires. A downstream segment-pattern matcher reads the output word once per crossing.

Top module: `drift_hit_classifier`

## Requirements
- R1: A synchronous active-high reset clears the output word, the valid pulse and all per-wire build-up state. A period that was running when reset arrived reports all zeros at the first strobe after reset.
- R2: `flagsValid` is high for exactly one cycle, the cycle after each cycle in which `crossStrobe` is high. `flagsOut` changes only in that cycle and holds its value between strobes.
- R3: In `flagsOut`, bit 2w is the prompt flag of wire w and bit 2w+1 is its delayed flag. The word reports the hits of the period that the strobe just closed.
- R4: The cycle in which `crossStrobe` is high is tick 0, and each later cycle adds one to the tick. A hit at a tick below `promptEnd` sets the prompt flag.
- R5: A hit at a tick from `promptEnd` up to `delayedEnd`-1 sets the delayed flag. A hit at exactly tick `promptEnd` counts as delayed, not prompt.
- R6: A hit at a tick of `delayedEnd` or later leaves both flags of that wire unchanged.
- R7: One wire can report both its prompt flag and its delayed flag in the same period.
- R8: Several hits on one wire in the same window leave that flag at 1. The flags do not count hits.
- R9: No hit is lost at a period boundary. A hit in the last cycle of a period counts in the period that closes. A hit in the strobe cycle counts in the new period, at tick 0.
- R10: Hits that arrive after reset and before the first crossing strobe are ignored. The tick counter saturates at its largest value, which lies beyond any delayed window.
- R11: `promptEnd` and `delayedEnd` are read every cycle, so new boundary values apply to the hits that follow the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is one tick |
| rst | input | 1 | Synchronous active-high reset |
| crossStrobe | input | 1 | Marks tick 0 of a new crossing period |
| promptEnd | input | TICK_W | First tick of the delayed window |
| delayedEnd | input | TICK_W | First tick past the delayed window |
| hitIn | input | NUM_WIRES | Per-wire discriminator hit pulses |
| flagsOut | output | 2*NUM_WIRES | Per-wire {delayed, prompt} flags of the last period |
| flagsValid | output | 1 | One-cycle pulse when flagsOut is updated |

## Verification
The hardest case to reach is the period boundary. A hit must land in the last tick of one period and another hit on the same wire must land in the strobe cycle, and each must be seen in its own output word. The last tick only counts as delayed if the delayed window reaches the end of the period. So the stimulus first widens `delayedEnd` beyond the strobe spacing. It then places one hit in the final cycle before a strobe and another in the strobe cycle itself, and reads the two words that follow. Reset in the middle of a period and hits that arrive before the first strobe are driven as separate scenes, so that stale build-up state would show up in the output.

// File: rtl/drift_cls_pkg.sv
package drift_cls_pkg;

  // Strobes from the control to the datapath. They are shared by every wire.
  typedef struct packed {
    logic capture;    // a period closes: move flags to the output, restart build-up
    logic inPrompt;   // the current tick lies in the prompt window
    logic inDelayed;  // the current tick lies in the delayed window
  } clsStrobe_t;

endpackage

// File: rtl/drift_cls_ctrl.sv
module drift_cls_ctrl
  import drift_cls_pkg::*;
#(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              crossStrobe,
  input  logic [TICK_W-1:0] promptEnd,
  input  logic [TICK_W-1:0] delayedEnd,
  output clsStrobe_t        strobes
);

  localparam logic [TICK_W-1:0] TICK_MAX = '1;

  logic [TICK_W-1:0] tickReg;
  logic [TICK_W-1:0] tickNow;
  logic              beforePrompt;
  logic              beforeDelayedEnd;

  // The strobe cycle is tick 0. The counter saturates so that a long gap,
  // or the time before the first strobe, falls beyond every window.
  always_comb begin
    if (crossStrobe)
      tickNow = '0;
    else if (tickReg == TICK_MAX)
      tickNow = TICK_MAX;
    else
      tickNow = tickReg + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      tickReg <= TICK_MAX;
    else
      tickReg <= tickNow;
  end

  // One pair of comparators serves the whole wire group.
  assign beforePrompt     = (tickNow < promptEnd);
  assign beforeDelayedEnd = (tickNow < delayedEnd);

  always_comb begin
    strobes.capture   = crossStrobe;
    strobes.inPrompt  = beforePrompt;
    strobes.inDelayed = !beforePrompt && beforeDelayedEnd;
  end

endmodule

// File: rtl/drift_cls_dpath.sv
module drift_cls_dpath
  import drift_cls_pkg::*;
#(
  parameter int NUM_WIRES = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  clsStrobe_t             strobes,
  input  logic [NUM_WIRES-1:0]   hitIn,
  output logic [2*NUM_WIRES-1:0] flagsOut,
  output logic                   flagsValid
);

  localparam int OUT_W = 2 * NUM_WIRES;

  logic [NUM_WIRES-1:0] accPrompt;
  logic [NUM_WIRES-1:0] accDelayed;
  logic [OUT_W-1:0]     outReg;
  logic                 validReg;

  for (genvar w = 0; w < NUM_WIRES; w++) begin : g_wire
    logic newPrompt;
    logic newDelayed;

    assign newPrompt  = hitIn[w] && strobes.inPrompt;
    assign newDelayed = hitIn[w] && strobes.inDelayed;

    always_ff @(posedge clk) begin
      if (rst) begin
        accPrompt[w]     <= 1'b0;
        accDelayed[w]    <= 1'b0;
        outReg[2*w]      <= 1'b0;
        outReg[2*w+1]    <= 1'b0;
      end else if (strobes.capture) begin
        // Hand over the closing period and start the new one with this cycle's hit.
        outReg[2*w]      <= accPrompt[w];
        outReg[2*w+1]    <= accDelayed[w];
        accPrompt[w]     <= newPrompt;
        accDelayed[w]    <= newDelayed;
      end else begin
        accPrompt[w]     <= accPrompt[w] | newPrompt;
        accDelayed[w]    <= accDelayed[w] | newDelayed;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      validReg <= 1'b0;
    else
      validReg <= strobes.capture;
  end

  assign flagsOut   = outReg;
  assign flagsValid = validReg;

endmodule

// File: rtl/drift_hit_classifier.sv
module drift_hit_classifier
  import drift_cls_pkg::*;
#(
  parameter int NUM_WIRES = 12,
  parameter int TICK_W    = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   crossStrobe,
  input  logic [TICK_W-1:0]      promptEnd,
  input  logic [TICK_W-1:0]      delayedEnd,
  input  logic [NUM_WIRES-1:0]   hitIn,
  output logic [2*NUM_WIRES-1:0] flagsOut,
  output logic                   flagsValid
);

  clsStrobe_t strobes;

  drift_cls_ctrl #(.TICK_W(TICK_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .crossStrobe(crossStrobe),
    .promptEnd  (promptEnd),
    .delayedEnd (delayedEnd),
    .strobes    (strobes)
  );

  drift_cls_dpath #(.NUM_WIRES(NUM_WIRES)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .hitIn     (hitIn),
    .flagsOut  (flagsOut),
    .flagsValid(flagsValid)
  );

endmodule

// File: rtl/drift_cls_checker.sv
module drift_cls_checker #(
  parameter int NUM_WIRES = 12,
  parameter int TICK_W    = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   crossStrobe,
  input logic [TICK_W-1:0]      promptEnd,
  input logic [TICK_W-1:0]      delayedEnd,
  input logic [NUM_WIRES-1:0]   hitIn,
  input logic [2*NUM_WIRES-1:0] flagsOut,
  input logic                   flagsValid
);

  // R1: one cycle after reset, outputs are cleared
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (flagsOut == '0 && !flagsValid));

  // R2: a strobe is followed by a valid pulse
  p_valid_follows_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    crossStrobe |=> flagsValid);

  // R2: no valid pulse without a strobe in the cycle before
  p_valid_needs_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    !crossStrobe |=> !flagsValid);

  // R2: the output word holds between strobes
  p_flags_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !crossStrobe |=> $stable(flagsOut));

endmodule

bind drift_hit_classifier drift_cls_checker #(
  .NUM_WIRES(NUM_WIRES),
  .TICK_W   (TICK_W)
) u_chk (.*);

// File: tb/sim_drift_hit_classifier.sv
module sim_drift_hit_classifier;

  localparam int NW  = 12;
  localparam int TW  = 8;
  localparam int PER = 20;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            crossStrobe = 1'b0;
  logic [TW-1:0]   promptEnd = 8'd5;
  logic [TW-1:0]   delayedEnd = 8'd12;
  logic [NW-1:0]   hitIn = '0;
  logic [2*NW-1:0] flagsOut;
  logic            flagsValid;

  int total = 0;
  int bad   = 0;

  logic [NW-1:0]   pat [PER];
  logic [NW-1:0]   expP = '0;
  logic [NW-1:0]   expD = '0;
  logic [2*NW-1:0] prevExp = '0;
  logic            started = 1'b0;
  string           curTag = "R10";
  string           prevTag = "R10";

  always #5 clk = ~clk;

  drift_hit_classifier #(.NUM_WIRES(NW), .TICK_W(TW)) u0 (
    .clk(clk), .rst(rst), .crossStrobe(crossStrobe),
    .promptEnd(promptEnd), .delayedEnd(delayedEnd),
    .hitIn(hitIn), .flagsOut(flagsOut), .flagsValid(flagsValid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [2*NW-1:0] packExp(input logic [NW-1:0] p, input logic [NW-1:0] d);
    logic [2*NW-1:0] r;
    for (int w = 0; w < NW; w++) begin
      r[2*w]   = p[w];
      r[2*w+1] = d[w];
    end
    return r;
  endfunction

  task automatic clearPat();
    for (int i = 0; i < PER; i++) pat[i] = '0;
  endtask

  // One crossing period: the strobe at tick 0, then pat[t] at tick t.
  // The word of the period before is checked right after this strobe.
  task automatic runPeriod(input string tag);
    bit extra = 0;
    for (int t = 0; t < PER; t++) begin
      @(negedge clk);
      if (t == 1) begin
        check(flagsValid == 1'b1, {prevTag, " R2 valid"}, 32'(flagsValid), 32'd1);
        check(flagsOut == prevExp, {prevTag, " R3 word"}, 32'(flagsOut), 32'(prevExp));
      end
      if (t >= 2 && flagsValid) extra = 1;
      crossStrobe = (t == 0);
      hitIn = pat[t];
      if (t == 0) begin
        prevExp = packExp(expP, expD);
        prevTag = curTag;
        curTag  = tag;
        expP = '0;
        expD = '0;
        started = 1'b1;
      end
      if (started) begin
        if (t < int'(promptEnd)) expP |= pat[t];
        else if (t < int'(delayedEnd)) expD |= pat[t];
      end
    end
    check(extra == 0, {tag, " R2 single pulse"}, 32'(extra), 32'd0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; crossStrobe = 1'b0; hitIn = '0;
    repeat (2) @(negedge clk);
    check(flagsOut == '0, "R1 flags", 32'(flagsOut), 32'd0);
    check(flagsValid == 1'b0, "R1 valid", 32'(flagsValid), 32'd0);
    rst = 1'b0;
    expP = '0; expD = '0; started = 1'b0; curTag = "R1 R10";
  endtask

  // R10: hits before the first strobe are dropped
  task automatic testBeforeFirst();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      hitIn = '1;
    end
    clearPat();
    runPeriod("R4 empty");
  endtask

  // R4 R9: prompt window, including hits in the strobe cycle and at tick promptEnd-1
  task automatic testPrompt();
    clearPat();
    pat[0] = 12'h00F;
    pat[4] = 12'h0F0;
    runPeriod("R4 R9 prompt");
  endtask

  // R5 R6: tick promptEnd is delayed, tick delayedEnd and later are ignored
  task automatic testDelayed();
    clearPat();
    pat[5]  = 12'h00F;
    pat[11] = 12'h100;
    pat[12] = 12'hE00;
    pat[19] = 12'hE00;
    runPeriod("R5 R6 delayed");
  endtask

  // R7 R8: both flags on one wire, repeated hits stay at 1
  task automatic testBothAndRepeat();
    clearPat();
    pat[2] = 12'h020;
    pat[7] = 12'h020;
    pat[1] = 12'h040;
    pat[2] = 12'h060;
    pat[3] = 12'h040;
    pat[8] = 12'h400;
    pat[9] = 12'h400;
    runPeriod("R7 R8 both");
  endtask

  // R11: new boundaries apply to the hits that follow
  task automatic testWindows();
    promptEnd = 8'd2;
    delayedEnd = 8'd8;
    clearPat();
    pat[1] = 12'h001;
    pat[2] = 12'h002;
    pat[7] = 12'h004;
    pat[8] = 12'h008;
    runPeriod("R11 windows");
  endtask

  // R9: last tick of one period and strobe cycle of the next
  task automatic testBoundary();
    promptEnd = 8'd5;
    delayedEnd = 8'd25;
    clearPat();
    pat[19] = 12'h008;
    runPeriod("R9 tail");
    clearPat();
    pat[0] = 12'h008;
    runPeriod("R9 head");
  endtask

  // R1: reset mid-period drops the build-up
  task automatic testMidReset();
    promptEnd = 8'd5;
    delayedEnd = 8'd12;
    clearPat();
    pat[0] = 12'hFFF;
    pat[6] = 12'hFFF;
    runPeriod("R1 lost");
    doReset();
    clearPat();
    runPeriod("R1 after");
  endtask

  initial begin
    clearPat();
    repeat (3) @(negedge clk);
    check(flagsOut == '0, "R1 flags", 32'(flagsOut), 32'd0);
    check(flagsValid == 1'b0, "R1 valid", 32'(flagsValid), 32'd0);
    rst = 1'b0;
    testBeforeFirst();
    testPrompt();
    testDelayed();
    testBothAndRepeat();
    testWindows();
    testBoundary();
    testMidReset();
    clearPat();
    runPeriod("flush");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule